// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A requester, typically a translation cache that has just missed, hands over a virtual address and the kind of access (load, store or instruction fetch). The walker then issues two dependent reads on a simple memory read port and returns either a physical address or a fault code.

The virtual address is split into a 12-bit page offset and a 20-bit page number. The page number is in turn split into an upper 10-bit index into the first-level (directory) table and a lower 10-bit index into a second-level table. A base input gives the physical address of the directory. A length input gives the number of directory entries that are usable. Every table entry is one 32-bit word. Bits 31:12 hold a frame number, which is either the page frame or the frame of the next table. Bit 0 marks the entry valid, bit 1 marks it read-only, bit 2 marks it no-execute, and bit 3 is a dirty flag that the walker does not consult.

Only one walk runs at a time. A new request is accepted only while the walker is idle, and the result is presented as a one-cycle pulse.

Top module: `pt_walker`

## Requirements
- R1: Out of reset the walker is idle: `reqReady` is 1, and `memReqValid` and `rspValid` are 0.
- R2: For an accepted request, the first memory read is at `tableBase + vaddr[31:22]*4`.
- R3: If `vaddr[31:22]` is greater than or equal to `tableLen`, the walker makes no memory read. It answers in the cycle after acceptance with fault code 1 (address fault).
- R4: The second memory read is at `{outerEntry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: At most one memory read is outstanding at a time. A read request holds its valid and address stable until `memReqReady` is seen.
- R6: An entry with bit 0 clear, at either level, ends the walk with fault code 2 (page fault). No further read is made after it.
- R7: When both entries pass their checks, the response carries fault code 0 and the physical address `{innerEntry[31:12], vaddr[11:0]}`.
- R8: Access codes are 0 = read, 1 = write and 2 = fetch. A write through an entry with bit 1 set, or a fetch through an entry with bit 2 set, ends the walk with fault code 3 (protection fault). This check is made at both levels, and it ends the walk at the level where it occurs. Reads ignore bits 1 and 2, and bit 3 never affects the result.
- R9: Each accepted request produces exactly one response, and `rspValid` is high for a single cycle. `reqReady` is 0 from acceptance until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqAccess | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| tableBase | input | 32 | Physical address of the directory table |
| tableLen | input | 11 | Number of usable directory entries (0 to 1024) |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRespValid | input | 1 | Read data returned |
| memRespData | input | 32 | Table entry word |
| rspValid | output | 1 | One-cycle result strobe |
| rspPaddr | output | 32 | Translated physical address (meaningful when fault is 0) |
| rspFault | output | 2 | 0 none, 1 address, 2 page, 3 protection |

## Verification
The bench builds the walker with its default parameters: 12 offset bits, 10 index bits per level, 32-bit entries, and the permission check enabled at the directory level. With these values the length bound spans 0 to 1024, so the bench can drive the exact boundary, where the index equals the length, and also a length of zero. Because the directory check is enabled, a protection fault can be raised after a single read as well as after two. The memory model randomly stalls `memReqReady` and delays read data, so the held-request rule and the single-outstanding rule are both exercised under back-pressure.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE
  } walkState_e;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_ADDR = 2'd1;
  localparam logic [1:0] FLT_PAGE = 2'd2;
  localparam logic [1:0] FLT_PROT = 2'd3;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int VALID_BIT = 0;
  localparam int RO_BIT    = 1;
  localparam int NX_BIT    = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeReq;     // latch request fields
    logic takeOuter;   // latch next-table frame
    logic takeInner;   // latch page frame
    logic innerLevel;  // second-level read in progress
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter bit CHECK_OUTER_PERM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [PA_W-1:0]   tableBase,
  input  logic [IDX_W:0]    tableLen,
  input  logic [PA_W-1:0]   memRespData,
  output logic              outOfRange,
  output logic              entryValid,
  output logic              permFail,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   rspPaddr
);

  localparam int FRAME_W   = PA_W - OFF_W;
  localparam int ENT_SHIFT = $clog2(PA_W / 8);
  localparam int OUTER_LSB = OFF_W + IDX_W;

  logic [VA_W-1:0]    vaReg;
  logic [1:0]         accReg;
  logic [PA_W-1:0]    baseReg;
  logic [FRAME_W-1:0] nextTbl;
  logic [FRAME_W-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      accReg   <= ACC_READ;
      baseReg  <= '0;
      nextTbl  <= '0;
      frameReg <= '0;
    end else begin
      if (strobe.takeReq) begin
        vaReg   <= reqVaddr;
        accReg  <= reqAccess;
        baseReg <= tableBase;
      end
      if (strobe.takeOuter) nextTbl  <= memRespData[PA_W-1 -: FRAME_W];
      if (strobe.takeInner) frameReg <= memRespData[PA_W-1 -: FRAME_W];
    end
  end

  // Bound check on the live request, before anything is latched
  logic [IDX_W-1:0] liveOuterIdx;
  assign liveOuterIdx = reqVaddr[OUTER_LSB +: IDX_W];
  assign outOfRange   = {1'b0, liveOuterIdx} >= tableLen;

  // Entry addresses
  logic [IDX_W-1:0] outerIdx, innerIdx;
  logic [PA_W-1:0]  outerAddr, innerAddr;
  assign outerIdx  = vaReg[OUTER_LSB +: IDX_W];
  assign innerIdx  = vaReg[OFF_W +: IDX_W];
  assign outerAddr = baseReg + (PA_W'(outerIdx) << ENT_SHIFT);
  assign innerAddr = {nextTbl, {OFF_W{1'b0}}} + (PA_W'(innerIdx) << ENT_SHIFT);
  assign memReqAddr = strobe.innerLevel ? innerAddr : outerAddr;

  // Entry checks
  logic roHit, nxHit;
  assign entryValid = memRespData[VALID_BIT];
  assign roHit = (accReg == ACC_WRITE) && memRespData[RO_BIT];
  assign nxHit = (accReg == ACC_FETCH) && memRespData[NX_BIT];

  generate
    if (CHECK_OUTER_PERM) begin : g_bothLevels
      assign permFail = roHit | nxHit;
    end else begin : g_leafOnly
      assign permFail = strobe.innerLevel & (roHit | nxHit);
    end
  endgenerate

  assign rspPaddr = {frameReg, vaReg[OFF_W-1:0]};

  logic unusedEntryBits;
  assign unusedEntryBits = ^memRespData[OFF_W-1:NX_BIT+1];

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        outOfRange,
  input  logic        entryValid,
  input  logic        permFail,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output logic [1:0]  rspFault,
  output walkStrobe_t strobe
);

  walkState_e state, stateNext;
  logic [1:0] faultReg, faultNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= FLT_NONE;
    end else begin
      state    <= stateNext;
      faultReg <= faultNext;
    end
  end

  always_comb begin
    stateNext = state;
    faultNext = faultReg;
    strobe    = '0;
    strobe.innerLevel = (state == ST_RD_INNER) || (state == ST_WT_INNER);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.takeReq = 1'b1;
          if (outOfRange) begin
            faultNext = FLT_ADDR;
            stateNext = ST_DONE;
          end else begin
            faultNext = FLT_NONE;
            stateNext = ST_RD_OUTER;
          end
        end
      end
      ST_RD_OUTER: if (memReqReady) stateNext = ST_WT_OUTER;
      ST_WT_OUTER: begin
        if (memRespValid) begin
          if (!entryValid) begin
            faultNext = FLT_PAGE;
            stateNext = ST_DONE;
          end else if (permFail) begin
            faultNext = FLT_PROT;
            stateNext = ST_DONE;
          end else begin
            strobe.takeOuter = 1'b1;
            stateNext = ST_RD_INNER;
          end
        end
      end
      ST_RD_INNER: if (memReqReady) stateNext = ST_WT_INNER;
      ST_WT_INNER: begin
        if (memRespValid) begin
          stateNext = ST_DONE;
          if (!entryValid)   faultNext = FLT_PAGE;
          else if (permFail) faultNext = FLT_PROT;
          else begin
            faultNext = FLT_NONE;
            strobe.takeInner = 1'b1;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign rspValid    = (state == ST_DONE);
  assign rspFault    = faultReg;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter bit CHECK_OUTER_PERM = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [PA_W-1:0]  tableBase,
  input  logic [IDX_W:0]   tableLen,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRespValid,
  input  logic [PA_W-1:0]  memRespData,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspFault
);

  walkStrobe_t strobe;
  logic outOfRange, entryValid, permFail;

  pt_walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRespValid(memRespValid),
    .outOfRange  (outOfRange),
    .entryValid  (entryValid),
    .permFail    (permFail),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .rspFault    (rspFault),
    .strobe      (strobe)
  );

  pt_walker_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .CHECK_OUTER_PERM(CHECK_OUTER_PERM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .tableBase  (tableBase),
    .tableLen   (tableLen),
    .memRespData(memRespData),
    .outOfRange (outOfRange),
    .entryValid (entryValid),
    .permFail   (permFail),
    .memReqAddr (memReqAddr),
    .rspPaddr   (rspPaddr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [VA_W-1:0]  reqVaddr,
  input logic [IDX_W:0]   tableLen,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [PA_W-1:0]  memReqAddr,
  input logic             memRespValid,
  input logic [PA_W-1:0]  memRespData,
  input logic             rspValid,
  input logic [1:0]       rspFault
);

  logic [1:0] inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 2'((memReqValid && memReqReady) ? 1 : 0)
                              - 2'(memRespValid ? 1 : 0);
  end

  // R5
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (inFlight == 2'd0));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || memReqValid) |-> !reqReady);

  // R3
  range_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && ({1'b0, reqVaddr[OFF_W+IDX_W +: IDX_W]} >= tableLen))
    |=> (rspValid && rspFault == 2'd1 && !memReqValid));

  // R6
  invalid_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRespValid && !memRespData[0]) |=> (rspValid && rspFault == 2'd2));

endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqVaddr(reqVaddr), .tableLen(tableLen), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRespValid(memRespValid), .memRespData(memRespData),
  .rspValid(rspValid), .rspFault(rspFault)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [31:0] tableBase = 32'h0000_2000;
  logic [10:0] tableLen = 11'd16;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic [1:0]  rspFault;

  always #2 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .tableBase(tableBase),
    .tableLen(tableLen), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] mem [4096];
  int          logCnt = 0;
  logic [31:0] logAddr [4];
  bit          overlap = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: random back-pressure and latency
  initial begin
    forever begin
      @(negedge clk);
      if (memReqValid && rstN) begin
        memReqReady = ($urandom % 3) != 0;
        if (memReqReady) begin
          if (logCnt < 4) logAddr[logCnt] = memReqAddr;
          logCnt++;
          @(negedge clk);
          memReqReady = 1'b0;
          repeat ($urandom % 4) begin
            @(negedge clk);
            if (memReqValid) overlap = 1'b1;
          end
          memRespData  = mem[memReqAddr[13:2]];
          memRespValid = 1'b1;
          @(negedge clk);
          memRespValid = 1'b0;
        end
      end
    end
  end

  // Reference model from the requirements
  task automatic predict(input logic [31:0] va, input logic [1:0] acc,
                         output logic [1:0] fault, output logic [31:0] pa,
                         output int nReads, output logic [31:0] a0,
                         output logic [31:0] a1);
    logic [31:0] e0, e1;
    fault = 2'd0; pa = '0; nReads = 0; a0 = '0; a1 = '0;
    if ({1'b0, va[31:22]} >= tableLen) begin
      fault = 2'd1;
      return;
    end
    a0 = tableBase + {20'd0, va[31:22], 2'b00};
    nReads = 1;
    e0 = mem[a0[13:2]];
    if (!e0[0]) begin fault = 2'd2; return; end
    if ((acc == 2'd1 && e0[1]) || (acc == 2'd2 && e0[2])) begin fault = 2'd3; return; end
    a1 = {e0[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    nReads = 2;
    e1 = mem[a1[13:2]];
    if (!e1[0]) begin fault = 2'd2; return; end
    if ((acc == 2'd1 && e1[1]) || (acc == 2'd2 && e1[2])) begin fault = 2'd3; return; end
    pa = {e1[31:12], va[11:0]};
  endtask

  task automatic run(input logic [31:0] va, input logic [1:0] acc);
    logic [1:0] ef; logic [31:0] ep, a0, a1; int nr; int n;
    string ftag;
    predict(va, acc, ef, ep, nr, a0, a1);
    @(negedge clk);
    logCnt = 0;
    overlap = 1'b0;
    reqVaddr = va; reqAccess = acc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", 32'(reqReady), 32'd0);
    n = 0;
    while (!rspValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(rspValid == 1'b1, "R9 response arrives", 32'(rspValid), 32'd1);
    case (ef)
      2'd1: ftag = "R3 fault code";
      2'd2: ftag = "R6 fault code";
      2'd3: ftag = "R8 fault code";
      default: ftag = "R7 fault code";
    endcase
    check(rspFault == ef, ftag, 32'(rspFault), 32'(ef));
    check(logCnt == nr, "R3/R6 read count", 32'(logCnt), 32'(nr));
    if (nr >= 1 && logCnt >= 1)
      check(logAddr[0] == a0, "R2 directory address", logAddr[0], a0);
    if (nr >= 2 && logCnt >= 2)
      check(logAddr[1] == a1, "R4 leaf address", logAddr[1], a1);
    if (ef == 2'd0)
      check(rspPaddr == ep, "R7 physical address", rspPaddr, ep);
    check(!overlap, "R5 single outstanding", 32'(overlap), 32'd0);
    @(negedge clk);
    check(rspValid == 1'b0, "R9 single-cycle response", 32'(rspValid), 32'd0);
  endtask

  function automatic logic [31:0] word(input logic [31:0] a);
    return {18'd0, a[13:2], 2'b00};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", 32'(reqReady), 32'd1);
    check(memReqValid == 1'b0, "R1 memReqValid", 32'(memReqValid), 32'd0);
    check(rspValid == 1'b0, "R1 rspValid", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 idle after reset", 32'(reqReady), 32'd1);

    // Directed: directory at 0x2000, leaf table at 0x1000
    tableBase = 32'h0000_2000;
    tableLen  = 11'd16;
    mem[(32'h2000 + 3*4) >> 2] = {20'h00001, 12'h001};
    mem[(32'h1000 + 5*4) >> 2] = {20'hABCDE, 12'h001};
    run({10'd3, 10'd5, 12'h123}, 2'd0);                  // R7 plain read
    mem[(32'h1000 + 5*4) >> 2] = {20'hABCDE, 12'h009};   // dirty set
    run({10'd3, 10'd5, 12'hFFF}, 2'd1);                  // R8 dirty ignored
    run({10'd16, 10'd5, 12'h000}, 2'd0);                 // R3 index == length
    mem[(32'h2000 + 15*4) >> 2] = {20'h00001, 12'h001};
    run({10'd15, 10'd5, 12'h040}, 2'd0);                 // R3 index == length-1
    tableLen = 11'd0;
    run({10'd0, 10'd0, 12'h000}, 2'd2);                  // R3 zero length
    tableLen = 11'd1024;
    mem[(32'h2000 + 7*4) >> 2] = {20'h00001, 12'h000};
    run({10'd7, 10'd1, 12'h000}, 2'd0);                  // R6 directory invalid
    mem[(32'h1000 + 9*4) >> 2] = {20'h12345, 12'h000};
    run({10'd3, 10'd9, 12'h000}, 2'd0);                  // R6 leaf invalid
    mem[(32'h1000 + 10*4) >> 2] = {20'h22222, 12'h003};
    run({10'd3, 10'd10, 12'h010}, 2'd1);                 // R8 write to read-only
    run({10'd3, 10'd10, 12'h010}, 2'd0);                 // R8 read of read-only
    mem[(32'h1000 + 11*4) >> 2] = {20'h33333, 12'h005};
    run({10'd3, 10'd11, 12'h020}, 2'd2);                 // R8 fetch from no-execute
    run({10'd3, 10'd11, 12'h020}, 2'd1);                 // R8 write to no-execute
    mem[(32'h2000 + 20*4) >> 2] = {20'h00001, 12'h003};
    run({10'd20, 10'd5, 12'h000}, 2'd1);                 // R8 directory read-only
    run({10'd20, 10'd5, 12'h000}, 2'd2);                 // R8 fetch through it
    tableBase = 32'h0000_2FFC - 32'd4 * 32'd1023;
    mem[word(tableBase + 32'd4 * 32'd1023) >> 2] = {20'h00003, 12'h001};
    mem[(32'h3000 + 1023*4) >> 2] = {20'hFFFFF, 12'h001};
    run({10'd1023, 10'd1023, 12'hABC}, 2'd0);            // R2 R4 top indices

    // Random walks over a random table image
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[0] = ($urandom % 5) != 0;
      w[1] = ($urandom % 4) == 0;
      w[2] = ($urandom % 4) == 0;
      mem[i] = w;
    end
    for (int k = 0; k < 60; k++) begin
      logic [31:0] va;
      tableBase = {18'd0, 2'b10, 12'($urandom % 1024) & 12'hFFC} ;
      tableLen  = 11'($urandom % 1025);
      va = $urandom;
      if (($urandom % 4) != 0 && tableLen != 0)
        va[31:22] = 10'($urandom % tableLen);
      run(va, 2'($urandom % 3));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule